// File: doc/BRIEF.md
# Delayed Interrupt Coalescer

This block turns per-packet completion pulses from a receive channel and a transmit channel into fewer interrupts. Each channel keeps a count of pending events. It raises its delayed interrupt when that count reaches a programmed limit, or when a programmed number of microsecond ticks has passed since the first pending event. Whichever condition comes first fires the interrupt. A channel whose enable flag is clear passes every event straight through to its status bit.

Software reaches the block through a small word-addressed register port. One packed word holds both channel settings. A second word holds the number of clock cycles per microsecond. There is also a write-one-to-clear status word and an interrupt enable word. The single interrupt line is the OR of every status bit that is both set and enabled.

Top module: `intr_coalescer`

## Requirements
- R1: After reset, the coalescing word reads 0x8404_8404. The timebase word reads the reset cycle count in bits 15:8, which is 0x0000_3200 by default. Status and enable read 0, and irq_o is low.
- R2: The register addresses are 0 for the coalescing word, 1 for the timebase word, 2 for status and 3 for enable. The receive channel uses bits 15:0 of the coalescing word and the transmit channel uses bits 31:16. In each channel half, bit 15 is the enable flag, bits 14:8 are the count limit and bits 7:0 are the tick limit. Status and enable both use bit 0 for receive and bit 1 for transmit. Register writes take effect on the next cycle, and reads are combinational.
- R3: On an enabled channel, the event that brings the pending count to the count limit sets the status bit on that clock edge and clears the pending state. A count limit of 0 acts as 1.
- R4: On an enabled channel, ticks are counted only while events are pending before the cycle. The status bit is set on the tick that brings the counted ticks to the tick limit, and the pending state is then cleared.
- R5: A tick limit of 0 turns off the timeout path, so only the count limit fires.
- R6: On a disabled channel, each event sets the status bit on the next edge, and no state is kept pending.
- R7: A tick occurs once every N cycles, where N is timebase bits 15:8. N of 0 or 1 gives a tick every cycle. A write to the timebase word restarts the tick phase, and the first tick follows N cycles later.
- R8: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. A firing in the same cycle as a clear leaves the bit set.
- R9: irq_o is high exactly when some status bit and its enable bit are both 1. A status bit stays set while its enable bit is clear.
- R10: The two channels run independently under any mix of events, settings and clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| rx_evt_i | input | 1 | Receive completion pulse |
| tx_evt_i | input | 1 | Transmit completion pulse |
| irq_o | output | 1 | Interrupt line |

## Verification
A wrong pending count or tick count in a channel shows up at the ports as a status bit and an interrupt that rise one or more cycles too early or too late. A bad count is visible on the edge of the event that should have fired. A bad tick count is visible within one tick period of the intended timeout. A wrong tick phase moves every timeout by the same cycle offset. The bench compares irq_o and the read data against a cycle-level model on every cycle, so any of these faults shows up on the first cycle where the outputs differ.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int NCH = 2;

  typedef enum logic [1:0] {
    A_CFG = 2'd0,
    A_GLB = 2'd1,
    A_STS = 2'd2,
    A_ENA = 2'd3
  } addr_e;

  typedef struct packed {
    logic       en;
    logic [6:0] max_cnt;
    logic [7:0] max_tmo;
  } chan_cfg_t;
endpackage

// File: rtl/coal_tick.sv
module coal_tick #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cyc_i,
  input  logic         restart_i,
  output logic         tick_o
);
  logic [W-1:0] presc_q;
  logic [W-1:0] cyc_m1;

  assign cyc_m1 = (cyc_i == '0) ? '0 : cyc_i - 1'b1;
  assign tick_o = presc_q >= cyc_m1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        presc_q <= '0;
    else if (restart_i) presc_q <= '0;
    else if (tick_o)    presc_q <= '0;
    else                presc_q <= presc_q + 1'b1;
  end
endmodule

// File: rtl/coal_chan.sv
module coal_chan
  import coal_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  chan_cfg_t cfg_i,
  input  logic      tick_i,
  input  logic      evt_i,
  output logic      fire_o
);
  logic [7:0] cnt_q, tmr_q;
  logic [7:0] cnt_nx;
  logic [8:0] tmr_inc;
  logic       pend, cnt_hit, tmo_hit;

  assign pend    = cnt_q != '0;
  assign cnt_nx  = cnt_q + {7'd0, evt_i};
  assign cnt_hit = evt_i && (cnt_nx >= {1'b0, cfg_i.max_cnt});
  assign tmr_inc = {1'b0, tmr_q} + 9'd1;
  // timeout path idle when limit is zero
  assign tmo_hit = pend && tick_i && (cfg_i.max_tmo != '0) &&
                   (tmr_inc >= {1'b0, cfg_i.max_tmo});
  assign fire_o  = cfg_i.en ? (cnt_hit || tmo_hit) : evt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tmr_q <= '0;
    end else if (!cfg_i.en || fire_o) begin
      cnt_q <= '0;
      tmr_q <= '0;
    end else begin
      cnt_q <= cnt_nx;
      if (pend && tick_i && tmr_q != 8'hff) tmr_q <= tmr_q + 1'b1;
    end
  end
endmodule

// File: rtl/coal_csr.sv
module coal_csr
  import coal_pkg::*;
#(
  parameter int          NC        = 2,
  parameter logic [31:0] CFG_RESET = 32'h8404_8404,
  parameter logic [7:0]  CYC_RESET = 8'd50
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic [NC-1:0] fire_i,
  output logic [31:0]   cfg_o,
  output logic [7:0]    cyc_o,
  output logic          glb_wr_o,
  output logic [NC-1:0] status_o,
  output logic [NC-1:0] ena_o
);
  logic [31:0]   cfg_q;
  logic [7:0]    cyc_q;
  logic [NC-1:0] status_q, ena_q, clr;

  assign glb_wr_o = we_i && (addr_i == A_GLB);
  assign clr      = (we_i && addr_i == A_STS) ? wdata_i[NC-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= CFG_RESET;
      cyc_q    <= CYC_RESET;
      status_q <= '0;
      ena_q    <= '0;
    end else begin
      if (we_i && addr_i == A_CFG) cfg_q <= wdata_i;
      if (glb_wr_o)                cyc_q <= wdata_i[15:8];
      if (we_i && addr_i == A_ENA) ena_q <= wdata_i[NC-1:0];
      // firing beats a same-cycle clear
      status_q <= (status_q & ~clr) | fire_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CFG: rdata_o = cfg_q;
      A_GLB: rdata_o[15:8] = cyc_q;
      A_STS: rdata_o[NC-1:0] = status_q;
      A_ENA: rdata_o[NC-1:0] = ena_q;
      default: rdata_o = '0;
    endcase
  end

  assign cfg_o    = cfg_q;
  assign cyc_o    = cyc_q;
  assign status_o = status_q;
  assign ena_o    = ena_q;
endmodule

// File: rtl/intr_coalescer.sv
module intr_coalescer
  import coal_pkg::*;
#(
  parameter logic [31:0] CFG_RESET = 32'h8404_8404,
  parameter logic [7:0]  CYC_RESET = 8'd50
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        rx_evt_i,
  input  logic        tx_evt_i,
  output logic        irq_o
);
  localparam int FW = 32 / NCH;

  logic [31:0]    cfg_q;
  logic [7:0]     cyc_q;
  logic           glb_wr, tick;
  logic [NCH-1:0] fire, status_q, ena_q, evt;

  assign evt = {tx_evt_i, rx_evt_i};

  coal_csr #(.NC(NCH), .CFG_RESET(CFG_RESET), .CYC_RESET(CYC_RESET)) u_csr (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .fire_i(fire),
    .cfg_o(cfg_q), .cyc_o(cyc_q), .glb_wr_o(glb_wr),
    .status_o(status_q), .ena_o(ena_q)
  );

  coal_tick #(.W(8)) u_tick (
    .clk_i, .rst_ni, .cyc_i(cyc_q), .restart_i(glb_wr), .tick_o(tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    coal_chan u_ch (
      .clk_i, .rst_ni,
      .cfg_i(chan_cfg_t'(cfg_q[FW*i +: FW])),
      .tick_i(tick), .evt_i(evt[i]), .fire_o(fire[i])
    );
  end

  assign irq_o = |(status_q & ena_q);
endmodule

// File: rtl/coal_chk.sv
module coal_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        we_i,
  input logic [1:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic [1:0]  evt_i,
  input logic [1:0]  chan_en_i,
  input logic [1:0]  status_i,
  input logic [1:0]  ena_i,
  input logic [7:0]  cyc_i,
  input logic        tick_i,
  input logic        irq_o
);
  for (genvar i = 0; i < 2; i++) begin : g_a
    // R6
    disabled_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] && !chan_en_i[i] |=> status_i[i]);
    // R8
    no_silent_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(status_i[i]) |-> $past(we_i && addr_i == 2'd2 && wdata_i[i]));
  end
  // R9
  masked_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ena_i == 2'b00) |-> !irq_o);
  // R7
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && cyc_i > 8'd1 && !(we_i && addr_i == 2'd1) |=> !tick_i);
endmodule

bind intr_coalescer coal_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
  .wdata_i(reg_wdata_i), .evt_i({tx_evt_i, rx_evt_i}),
  .chan_en_i({cfg_q[31], cfg_q[15]}), .status_i(status_q), .ena_i(ena_q),
  .cyc_i(cyc_q), .tick_i(tick), .irq_o(irq_o)
);

// File: tb/tb_intr_coalescer.sv
module tb_intr_coalescer;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rx = 1'b0, tx = 1'b0;
  logic        irq;

  int total = 0, bad = 0, cycles = 0;

  // reference state
  logic [31:0] m_cfg = 32'h8404_8404;
  logic [7:0]  m_g = 8'd50;
  logic [1:0]  m_st = '0, m_en = '0;
  int          m_presc = 0;
  int          m_cnt[2] = '{0, 0};
  int          m_tmr[2] = '{0, 0};

  always #10 clk = ~clk;

  intr_coalescer dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rx_evt_i(rx), .tx_evt_i(tx),
    .irq_o(irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog req=all actual=%0d expected<=150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return m_cfg;
      2'd1: return {16'd0, m_g, 8'd0};
      2'd2: return {30'd0, m_st};
      default: return {30'd0, m_en};
    endcase
  endfunction

  // one clock: drive at negedge, check, advance model
  task automatic cyc(string tag, logic w, logic [1:0] a, logic [31:0] d, logic r, logic t);
    int cm1;
    bit tk;
    logic [1:0] f;
    logic [1:0] ev;
    we = w; addr = a; wdata = d; rx = r; tx = t;
    #1;
    chk(tag, rdata, m_read(a));
    chk(tag, {31'd0, irq}, {31'd0, |(m_st & m_en)});
    cm1 = (m_g == 0) ? 0 : int'(m_g) - 1;
    tk = m_presc >= cm1;
    ev = {t, r};
    for (int c = 0; c < 2; c++) begin
      logic [15:0] cf;
      int n;
      bit hc, ht;
      cf = m_cfg[16*c +: 16];
      n = m_cnt[c] + int'(ev[c]);
      hc = ev[c] && n >= int'(cf[14:8]);
      ht = m_cnt[c] != 0 && tk && cf[7:0] != 0 && m_tmr[c] + 1 >= int'(cf[7:0]);
      f[c] = cf[15] ? (hc || ht) : ev[c];
      if (!cf[15] || f[c]) begin
        m_cnt[c] = 0; m_tmr[c] = 0;
      end else begin
        if (m_cnt[c] != 0 && tk && m_tmr[c] != 255) m_tmr[c]++;
        m_cnt[c] = n;
      end
    end
    if (w && a == 2'd2) m_st = m_st & ~d[1:0];
    m_st = m_st | f;
    if (w && a == 2'd1) m_presc = 0;
    else if (tk) m_presc = 0;
    else m_presc++;
    if (w && a == 2'd0) m_cfg = d;
    if (w && a == 2'd1) m_g = d[15:8];
    if (w && a == 2'd3) m_en = d[1:0];
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 1'b0, 2'd2, '0, 1'b0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h5eed_c0a1));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset values
    chk("R1", {31'd0, irq}, 32'd0);
    for (int a = 0; a < 4; a++) cyc("R1", 1'b0, a[1:0], '0, 1'b0, 1'b0);
    // R2 R7 timebase 3 cycles, enable both
    cyc("R7", 1'b1, 2'd1, 32'h0000_0300, 1'b0, 1'b0);
    cyc("R2", 1'b1, 2'd3, 32'h3, 1'b0, 1'b0);
    // R3 R5 rx count 3 no timeout, tx disabled
    cyc("R2", 1'b1, 2'd0, 32'h0000_8300, 1'b0, 1'b0);
    cyc("R3", 1'b0, 2'd2, '0, 1'b1, 1'b0);
    idle("R5", 20);
    cyc("R3", 1'b0, 2'd2, '0, 1'b1, 1'b0);
    cyc("R3", 1'b0, 2'd2, '0, 1'b1, 1'b0);
    idle("R3", 2);
    // R8 clear with zero bits, then ones
    cyc("R8", 1'b1, 2'd2, 32'h0, 1'b0, 1'b0);
    idle("R8", 1);
    cyc("R8", 1'b1, 2'd2, 32'h1, 1'b0, 1'b0);
    idle("R8", 1);
    // R6 disabled tx passes each event
    cyc("R6", 1'b0, 2'd2, '0, 1'b0, 1'b1);
    idle("R6", 2);
    // R8 clear and fire same cycle
    cyc("R8", 1'b1, 2'd2, 32'h2, 1'b0, 1'b1);
    idle("R8", 2);
    cyc("R8", 1'b1, 2'd2, 32'h3, 1'b0, 1'b0);
    // R4 timeout 2 ticks, count 10
    cyc("R4", 1'b1, 2'd0, 32'h0000_8A02, 1'b0, 1'b0);
    cyc("R4", 1'b0, 2'd2, '0, 1'b1, 1'b0);
    idle("R4", 12);
    // R3 zero count limit acts as one
    cyc("R3", 1'b1, 2'd0, 32'h0000_8000, 1'b0, 1'b0);
    cyc("R3", 1'b1, 2'd2, 32'h3, 1'b1, 1'b0);
    idle("R3", 2);
    // R9 masked status persists, unmask raises irq
    cyc("R9", 1'b1, 2'd3, 32'h0, 1'b0, 1'b0);
    idle("R9", 4);
    cyc("R9", 1'b1, 2'd3, 32'h1, 1'b0, 1'b0);
    idle("R9", 2);
    // R7 every-cycle tick
    cyc("R7", 1'b1, 2'd1, 32'h0000_0000, 1'b0, 1'b0);
    cyc("R7", 1'b1, 2'd0, 32'h8103_8203, 1'b1, 1'b1);
    idle("R7", 8);
    // R10 random mix
    for (int i = 0; i < 6000; i++) begin
      int sel;
      logic [31:0] d;
      logic r, t;
      sel = $urandom % 100;
      r = ($urandom % 3) == 0;
      t = ($urandom % 3) == 0;
      if (sel < 2) begin
        for (int c = 0; c < 2; c++) begin
          d[16*c+15]      = ($urandom % 4) != 0;
          d[16*c+8 +: 7]  = 7'($urandom % 9);
          d[16*c +: 8]    = 8'($urandom % 7);
        end
        cyc("R10", 1'b1, 2'd0, d, r, t);
      end else if (sel < 3) begin
        cyc("R10", 1'b1, 2'd1, {16'd0, 8'($urandom % 6), 8'd0}, r, t);
      end else if (sel < 6) begin
        cyc("R10", 1'b1, 2'd3, {30'd0, 2'($urandom)}, r, t);
      end else if (sel < 18) begin
        cyc("R10", 1'b1, 2'd2, {30'd0, 2'($urandom)}, r, t);
      end else begin
        cyc("R10", 1'b0, 2'($urandom), 32'($urandom), r, t);
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule